// File: doc/BRIEF.md
# Zero-Overhead Two-Level Loop Sequencer

This block sits beside the program counter and steers fetch for counted hardware loops, so that a loop body repeats without any branch instruction and without a prediction structure. It holds two loop contexts, an inner one and an outer one. Each context has a start address and a remaining-pass count. A setup command loads one context in a single operation. The loop end is not stored as an address. Instead, the last packet of each loop body carries an end flag for its level.

For every fetched packet, the sequencer looks at the two end flags and its own state, and picks the next fetch address in the same cycle. That address is either the sequential address supplied by the fetch unit or the start address of a loop. Because the choice is combinational, a loop-back costs no bubble cycle. The pass counts are updated on the clock edge that retires the packet.

Top module: `hwloop_seq`

## Requirements
- R1: While reset is asserted and directly after it, both loop levels are inactive and `next_fetch` equals `seq_addr`.
- R2: A setup command with `setup_level`=0 loads the inner context and with `setup_level`=1 loads the outer context; the loaded level reads active from the next cycle.
- R3: A setup command whose count is 0 loads a count of 1, so the body runs exactly once.
- R4: A valid packet with the end flag of an active level whose count is above 1 makes `next_fetch` that level's start address in the same cycle, and decrements the count.
- R5: A valid packet with the end flag of an active level whose count is 1 clears the count, makes the level inactive, and lets `next_fetch` fall through to `seq_addr`.
- R6: When one packet carries both end flags, the inner level is resolved first; the outer level is evaluated only if the inner level does not loop back, and it is left unchanged otherwise.
- R7: An end flag for an inactive level has no effect on `next_fetch` or on any count.
- R8: With `pkt_valid` low, the end flags are ignored, `next_fetch` equals `seq_addr`, and the counts hold.
- R9: A setup command for a level in the same cycle as an end flag for that level wins: the new start and count are loaded, while `next_fetch` for that cycle still follows the old state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| setup_valid | input | 1 | Load one loop context this cycle |
| setup_level | input | 1 | Context selected by setup: 0 inner, 1 outer |
| setup_start | input | ADDR_W | Start address to load |
| setup_count | input | CNT_W | Pass count to load (0 means 1) |
| pkt_valid | input | 1 | A packet is being fetched this cycle |
| end_inner | input | 1 | Packet is the last of the inner body |
| end_outer | input | 1 | Packet is the last of the outer body |
| seq_addr | input | ADDR_W | Sequential next address from the fetch unit |
| next_fetch | output | ADDR_W | Address to fetch next |
| inner_active | output | 1 | Inner loop has passes left |
| outer_active | output | 1 | Outer loop has passes left |

## Verification
A single inner loop is run down from several counts to show the loop-back, the decrement and the final fall-through apart. A nested pair with both end flags on the same packet separates inner-first priority from outer evaluation after the inner exit, and a zero-count setup tells the once-only rule from a skipped body. End flags on inactive levels and with no valid packet confirm they change nothing, a setup colliding with an end flag shows the load wins, and a long stretch of random setups and flags is compared cycle by cycle against a behavioural model.

// File: rtl/hwloop_seq.sv
module hwloop_seq #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              setup_valid,
  input  logic              setup_level,
  input  logic [ADDR_W-1:0] setup_start,
  input  logic [CNT_W-1:0]  setup_count,
  input  logic              pkt_valid,
  input  logic              end_inner,
  input  logic              end_outer,
  input  logic [ADDR_W-1:0] seq_addr,
  output logic [ADDR_W-1:0] next_fetch,
  output logic              inner_active,
  output logic              outer_active
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0]  in_cnt, out_cnt;
  logic [ADDR_W-1:0] in_start, out_start;

  assign inner_active = |in_cnt;
  assign outer_active = |out_cnt;

  wire in_hit   = pkt_valid & end_inner & inner_active;
  wire in_back  = in_hit & (in_cnt > ONE);
  wire out_hit  = pkt_valid & end_outer & outer_active & ~in_back;
  wire out_back = out_hit & (out_cnt > ONE);

  assign next_fetch = in_back ? in_start : (out_back ? out_start : seq_addr);

  wire             ld_in  = setup_valid & ~setup_level;
  wire             ld_out = setup_valid &  setup_level;
  wire [CNT_W-1:0] ld_cnt = (setup_count == '0) ? ONE : setup_count;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_cnt    <= '0;
      out_cnt   <= '0;
      in_start  <= '0;
      out_start <= '0;
    end else begin
      if (ld_in) begin
        in_cnt   <= ld_cnt;
        in_start <= setup_start;
      end else if (in_hit) begin
        in_cnt <= in_cnt - ONE;
      end
      if (ld_out) begin
        out_cnt   <= ld_cnt;
        out_start <= setup_start;
      end else if (out_hit) begin
        out_cnt <= out_cnt - ONE;
      end
    end
  end
endmodule

// File: rtl/hwloop_seq_chk.sv
module hwloop_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              setup_valid,
  input logic              setup_level,
  input logic [CNT_W-1:0]  setup_count,
  input logic              pkt_valid,
  input logic              end_inner,
  input logic              end_outer,
  input logic [ADDR_W-1:0] seq_addr,
  input logic [ADDR_W-1:0] next_fetch,
  input logic              inner_active,
  input logic              outer_active,
  input logic [CNT_W-1:0]  in_cnt,
  input logic [CNT_W-1:0]  out_cnt,
  input logic [ADDR_W-1:0] in_start
);
  wire ld_in  = setup_valid && !setup_level;
  wire ld_out = setup_valid && setup_level;

  a_r2_outer_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld_out |=> outer_active);

  a_r3_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    ld_in && setup_count == '0 |=> in_cnt == CNT_W'(1));

  a_r4_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && end_inner && in_cnt > CNT_W'(1) |-> next_fetch == in_start);

  a_r4_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && end_inner && in_cnt > CNT_W'(1) && !ld_in |=> in_cnt == $past(in_cnt) - CNT_W'(1));

  a_r5_last_pass: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && end_inner && in_cnt == CNT_W'(1) && !ld_in |=> !inner_active);

  a_r6_outer_held: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && end_inner && in_cnt > CNT_W'(1) && !ld_out |=> $stable(out_cnt));

  a_r7_idle_seq: assert property (@(posedge clk) disable iff (!rst_n)
    !inner_active && !outer_active |-> next_fetch == seq_addr);

  a_r7_outer_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !outer_active && pkt_valid && end_outer && !ld_out |=> !outer_active);

  a_r8_no_packet: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid && !setup_valid |=> $stable(in_cnt) && $stable(out_cnt));
endmodule

bind hwloop_seq hwloop_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .setup_valid(setup_valid), .setup_level(setup_level),
  .setup_count(setup_count), .pkt_valid(pkt_valid), .end_inner(end_inner),
  .end_outer(end_outer), .seq_addr(seq_addr), .next_fetch(next_fetch),
  .inner_active(inner_active), .outer_active(outer_active),
  .in_cnt(in_cnt), .out_cnt(out_cnt), .in_start(in_start)
);

// File: tb/hwloop_seq_bench.sv
module hwloop_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int CW = 8;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          setup_valid = 0, setup_level = 0;
  logic [AW-1:0] setup_start = '0;
  logic [CW-1:0] setup_count = '0;
  logic          pkt_valid = 0, end_inner = 0, end_outer = 0;
  logic [AW-1:0] seq_addr = '0;
  logic [AW-1:0] next_fetch;
  logic          inner_active, outer_active;

  int checks = 0, fails = 0;
  int m_ic = 0, m_oc = 0;
  int m_is = 0, m_os = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hwloop_seq #(.ADDR_W(AW), .CNT_W(CW)) u_hwloop_seq (
    .clk(clk), .rst_n(rst_n), .setup_valid(setup_valid), .setup_level(setup_level),
    .setup_start(setup_start), .setup_count(setup_count), .pkt_valid(pkt_valid),
    .end_inner(end_inner), .end_outer(end_outer), .seq_addr(seq_addr),
    .next_fetch(next_fetch), .inner_active(inner_active), .outer_active(outer_active)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic step(string tag, bit sv, bit sl, int ss, int sc,
                      bit pv, bit ei, bit eo, int sq);
    int nf, nic, noc;
    bit inner_back;
    @(negedge clk);
    setup_valid = sv; setup_level = sl; setup_start = AW'(ss); setup_count = CW'(sc);
    pkt_valid = pv; end_inner = ei; end_outer = eo; seq_addr = AW'(sq);
    #1;
    nf = sq; nic = m_ic; noc = m_oc; inner_back = 0;
    if (pv && ei && m_ic > 0) begin
      if (m_ic > 1) begin nf = m_is; inner_back = 1; end
      nic = m_ic - 1;
    end
    if (pv && eo && m_oc > 0 && !inner_back) begin
      if (m_oc > 1) nf = m_os;
      noc = m_oc - 1;
    end
    chk(tag, "next_fetch", int'(next_fetch), nf);
    chk(tag, "inner_active", int'(inner_active), int'(m_ic != 0));
    chk(tag, "outer_active", int'(outer_active), int'(m_oc != 0));
    if (sv && !sl) begin nic = (sc == 0) ? 1 : sc; m_is = ss; end
    if (sv && sl)  begin noc = (sc == 0) ? 1 : sc; m_os = ss; end
    @(posedge clk);
    m_ic = nic; m_oc = noc;
  endtask

  task automatic pkt(string tag, bit ei, bit eo, int sq);
    step(tag, 0, 0, 0, 0, 1, ei, eo, sq);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    seq_addr = 16'h0abc;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: state under reset
    chk("R1", "next_fetch", int'(next_fetch), 'h0abc);
    chk("R1", "inner_active", int'(inner_active), 0);
    chk("R1", "outer_active", int'(outer_active), 0);
    rst_n = 1;
    pkt("R1", 0, 0, 'h0010);

    // R2/R4/R5: inner loop, count 3
    step("R2", 1, 0, 'h0100, 3, 0, 0, 0, 'h0011);
    pkt("R2", 0, 0, 'h0101);
    pkt("R4", 1, 0, 'h0102);
    pkt("R4", 1, 0, 'h0102);
    pkt("R5", 1, 0, 'h0102);
    pkt("R5", 0, 0, 'h0103);

    // R3: zero count runs once
    step("R3", 1, 0, 'h0200, 0, 0, 0, 0, 'h0020);
    pkt("R3", 1, 0, 'h0201);
    pkt("R3", 0, 0, 'h0202);

    // R7: end flags with no active level
    pkt("R7", 1, 1, 'h0300);
    pkt("R7", 1, 1, 'h0301);

    // R6: nested, both flags on one packet
    step("R2", 1, 1, 'h0400, 2, 0, 0, 0, 'h0030);
    step("R2", 1, 0, 'h0480, 2, 0, 0, 0, 'h0031);
    pkt("R6", 1, 1, 'h0490);
    pkt("R6", 1, 1, 'h0490);
    step("R6", 1, 0, 'h0480, 2, 0, 0, 0, 'h0401);
    pkt("R6", 1, 1, 'h0490);
    pkt("R6", 1, 1, 'h0490);
    pkt("R6", 0, 0, 'h0491);

    // R7: outer flag while only inner active
    step("R7", 1, 0, 'h0500, 2, 0, 0, 0, 'h0040);
    pkt("R7", 0, 1, 'h0501);

    // R8: flags without a valid packet
    step("R8", 0, 0, 0, 0, 0, 1, 1, 'h0502);
    step("R8", 0, 0, 0, 0, 0, 1, 0, 'h0503);
    pkt("R8", 1, 0, 'h0504);
    pkt("R8", 1, 0, 'h0504);

    // R9: setup collides with end flag on same level
    step("R9", 1, 0, 'h0600, 3, 0, 0, 0, 'h0050);
    step("R9", 1, 0, 'h0700, 2, 1, 1, 0, 'h0601);
    pkt("R9", 1, 0, 'h0701);
    pkt("R9", 1, 0, 'h0701);

    // random traffic compared against the model
    for (int i = 0; i < 600; i++) begin
      bit sv = ($urandom % 8) == 0;
      step("R6", sv, 1'($urandom), int'($urandom % 'h1000), int'($urandom % 5),
           1'(($urandom % 4) != 0), 1'(($urandom % 3) == 0), 1'(($urandom % 4) == 0),
           int'($urandom % 'h1000));
    end

    summary();
    $finish;
  end
endmodule